// File: doc/BRIEF.md
# Depth-Tested Span Pixel Writer

This block is the last stage of a span rasterizer. Software or an upstream sequencer gives it a span: a base byte address in the colour buffer, a base byte address in the depth buffer and a pixel count. The shading front end then streams one pixel per transfer. Each pixel carries three 16-bit colour channels, its own 32-bit depth and the depth already held in the Z-buffer at that position. The stage reduces the colour to a 16-bit 5-5-5 word and tests the new depth against the stored one. When the test passes, it raises a colour store request and a depth store request. Whether or not the test passes, it moves both addresses on to the next pixel.

The pixel input and the two store outputs are valid/ready streams. A pixel is taken on a clock edge where `pix_valid` and `pix_ready` are both high. `pix_ready` is high only while a span is active and each store slot is either empty or being emptied in the same cycle. Each store request holds its address and data steady until its own ready is seen. A stalled colour store or a stalled depth store therefore holds back the pixel stream. Span start, busy and done are plain control pins.

Top module: `zpw_write_stage`

## Requirements
- R1: The stored colour word is {1'b0, red[15:11], green[15:11], blue[15:11]}: red in bits 14:10, green in bits 9:5, blue in bits 4:0, and bit 15 always 0.
- R2: A pixel passes the depth test only when its depth is strictly greater than the stored depth, with both compared as unsigned 32-bit values. Equal depths fail.
- R3: A colour store request is raised in the cycle after a pixel is taken if and only if that pixel passed the depth test.
- R4: A depth store request, carrying the pixel's incoming depth, is raised under exactly the same condition as the colour store.
- R5: The colour address of the i-th pixel of a span (i counted from 0) is colour base + 2*i. Its depth address is depth base + 4*i. Both wrap modulo 2^32, and failing pixels also advance the count i.
- R6: A span start is taken only while `span_busy` is low. A start asserted while busy is ignored.
- R7: `span_done` is high for one cycle, in the cycle after the last pixel of the span is taken, and `span_busy` falls in that same cycle. A span of length 0 raises `span_done` in the cycle after the start and never raises `span_busy`.
- R8: `pix_ready` is high exactly when `span_busy` is high and each store slot is empty or has its ready high. A store request that is not accepted keeps its valid, address and data unchanged.
- R9: During reset and after it, `span_busy`, `span_done`, `col_wr_valid` and `dep_wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| span_start | input | 1 | Request to begin a span; taken only while idle |
| span_col_base | input | 32 | Byte address of the first colour word |
| span_z_base | input | 32 | Byte address of the first depth word |
| span_len | input | 16 | Number of pixels in the span |
| span_busy | output | 1 | A span is in progress |
| span_done | output | 1 | One-cycle pulse after the last pixel is taken |
| pix_valid | input | 1 | Pixel stream valid |
| pix_ready | output | 1 | Pixel stream ready |
| pix_red | input | 16 | Red channel |
| pix_grn | input | 16 | Green channel |
| pix_blu | input | 16 | Blue channel |
| pix_z | input | 32 | Incoming depth |
| pix_zbuf | input | 32 | Depth read from the Z-buffer |
| col_wr_valid | output | 1 | Colour store request valid |
| col_wr_ready | input | 1 | Colour store request accepted |
| col_wr_addr | output | 32 | Colour store byte address |
| col_wr_data | output | 16 | Packed colour word |
| dep_wr_valid | output | 1 | Depth store request valid |
| dep_wr_ready | input | 1 | Depth store request accepted |
| dep_wr_addr | output | 32 | Depth store byte address |
| dep_wr_data | output | 32 | Depth value to store |

## Verification
The store requests, `span_busy` and `span_done` are registered. Each is due exactly one clock edge after the pixel transfer or span start that causes it. `pix_ready` is combinational and is due in the same cycle as the ready inputs it depends on. The bench drives inputs just after a falling edge. It first compares the registered outputs against a behavioural model that was advanced at the previous edge. After a short settle it compares `pix_ready`, then advances the model for the coming edge. In this way every result is checked in the cycle it falls due, under random back-pressure, equal and extreme depths, a zero-length span, a start while busy and address wrap.

// File: rtl/zpw_pkg.sv
package zpw_pkg;
  localparam int CHAN_W  = 16;
  localparam int FIELD_W = 5;
  localparam int WORD_W  = 16;

  typedef enum logic {ST_IDLE, ST_RUN} span_state_t;
endpackage

// File: rtl/zpw_color_pack.sv
module zpw_color_pack #(
  parameter int CH_W = zpw_pkg::CHAN_W,
  parameter int FW   = zpw_pkg::FIELD_W
) (
  input  logic [CH_W-1:0]         red,
  input  logic [CH_W-1:0]         grn,
  input  logic [CH_W-1:0]         blu,
  output logic [zpw_pkg::WORD_W-1:0] word
);
  localparam int NCH = 3;
  logic [CH_W-1:0] chan [NCH];
  logic [FW-1:0]   fld  [NCH];

  assign chan[0] = blu;
  assign chan[1] = grn;
  assign chan[2] = red;

  // keep the most significant bits of every channel
  for (genvar c = 0; c < NCH; c++) begin : g_trunc
    assign fld[c] = chan[c][CH_W-1 -: FW];
  end

  assign word = {1'b0, fld[2], fld[1], fld[0]};
endmodule

// File: rtl/zpw_depth_test.sv
module zpw_depth_test #(
  parameter int Z_W = 32
) (
  input  logic [Z_W-1:0] z_new,
  input  logic [Z_W-1:0] z_old,
  output logic           pass
);
  // unsigned, strict: ties keep the stored pixel
  assign pass = z_new > z_old;
endmodule

// File: rtl/zpw_span_ctrl.sv
module zpw_span_ctrl #(
  parameter int AW       = 32,
  parameter int CNT_W    = 16,
  parameter int COL_STEP = 2,
  parameter int Z_STEP   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    col_base,
  input  logic [AW-1:0]    z_base,
  input  logic [CNT_W-1:0] len,
  input  logic             advance,
  output logic             busy,
  output logic             done,
  output logic [AW-1:0]    col_addr,
  output logic [AW-1:0]    z_addr
);
  import zpw_pkg::*;

  localparam logic [AW-1:0]    COL_INC = AW'(COL_STEP);
  localparam logic [AW-1:0]    Z_INC   = AW'(Z_STEP);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  span_state_t      state;
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      remain   <= '0;
      col_addr <= '0;
      z_addr   <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (start) begin
          if (len == '0) begin
            done <= 1'b1;
          end else begin
            state    <= ST_RUN;
            remain   <= len;
            col_addr <= col_base;
            z_addr   <= z_base;
          end
        end
      end else if (advance) begin
        col_addr <= col_addr + COL_INC;
        z_addr   <= z_addr + Z_INC;
        remain   <= remain - ONE;
        if (remain == ONE) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end

  assign busy = (state == ST_RUN);
endmodule

// File: rtl/zpw_wr_slot.sv
module zpw_wr_slot #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  output logic          can_take
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_addr  <= ld_addr;
      out_data  <= ld_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/zpw_write_stage.sv
module zpw_write_stage #(
  parameter int AW    = 32,
  parameter int CNT_W = 16,
  parameter int CH_W  = zpw_pkg::CHAN_W,
  parameter int Z_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      span_start,
  input  logic [AW-1:0]             span_col_base,
  input  logic [AW-1:0]             span_z_base,
  input  logic [CNT_W-1:0]          span_len,
  output logic                      span_busy,
  output logic                      span_done,
  input  logic                      pix_valid,
  output logic                      pix_ready,
  input  logic [CH_W-1:0]           pix_red,
  input  logic [CH_W-1:0]           pix_grn,
  input  logic [CH_W-1:0]           pix_blu,
  input  logic [Z_W-1:0]            pix_z,
  input  logic [Z_W-1:0]            pix_zbuf,
  output logic                      col_wr_valid,
  input  logic                      col_wr_ready,
  output logic [AW-1:0]             col_wr_addr,
  output logic [zpw_pkg::WORD_W-1:0] col_wr_data,
  output logic                      dep_wr_valid,
  input  logic                      dep_wr_ready,
  output logic [AW-1:0]             dep_wr_addr,
  output logic [Z_W-1:0]            dep_wr_data
);
  localparam int CW = zpw_pkg::WORD_W;

  logic          take_pix;
  logic          z_pass;
  logic          store;
  logic          col_free, dep_free;
  logic [CW-1:0] packed_col;
  logic [AW-1:0] cur_col_addr, cur_z_addr;

  zpw_span_ctrl #(.AW(AW), .CNT_W(CNT_W), .COL_STEP(CW/8), .Z_STEP(Z_W/8)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (span_start),
    .col_base (span_col_base),
    .z_base   (span_z_base),
    .len      (span_len),
    .advance  (take_pix),
    .busy     (span_busy),
    .done     (span_done),
    .col_addr (cur_col_addr),
    .z_addr   (cur_z_addr)
  );

  zpw_color_pack #(.CH_W(CH_W)) u_pack (
    .red  (pix_red),
    .grn  (pix_grn),
    .blu  (pix_blu),
    .word (packed_col)
  );

  zpw_depth_test #(.Z_W(Z_W)) u_ztest (
    .z_new (pix_z),
    .z_old (pix_zbuf),
    .pass  (z_pass)
  );

  assign pix_ready = span_busy && col_free && dep_free;
  assign take_pix  = pix_valid && pix_ready;
  assign store     = take_pix && z_pass;

  zpw_wr_slot #(.AW(AW), .DW(CW)) u_col_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (store),
    .ld_addr   (cur_col_addr),
    .ld_data   (packed_col),
    .out_ready (col_wr_ready),
    .out_valid (col_wr_valid),
    .out_addr  (col_wr_addr),
    .out_data  (col_wr_data),
    .can_take  (col_free)
  );

  zpw_wr_slot #(.AW(AW), .DW(Z_W)) u_dep_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (store),
    .ld_addr   (cur_z_addr),
    .ld_data   (pix_z),
    .out_ready (dep_wr_ready),
    .out_valid (dep_wr_valid),
    .out_addr  (dep_wr_addr),
    .out_data  (dep_wr_data),
    .can_take  (dep_free)
  );
endmodule

// File: rtl/zpw_checker.sv
module zpw_checker #(
  parameter int AW    = 32,
  parameter int CNT_W = 16,
  parameter int CH_W  = 16,
  parameter int Z_W   = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 span_busy,
  input logic                 span_done,
  input logic                 pix_valid,
  input logic                 pix_ready,
  input logic [Z_W-1:0]       pix_z,
  input logic [Z_W-1:0]       pix_zbuf,
  input logic                 col_wr_valid,
  input logic                 col_wr_ready,
  input logic [AW-1:0]        col_wr_addr,
  input logic [15:0]          col_wr_data,
  input logic                 dep_wr_valid,
  input logic                 dep_wr_ready,
  input logic [AW-1:0]        dep_wr_addr,
  input logic [Z_W-1:0]       dep_wr_data
);
  // R8
  ready_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> span_busy);

  // R7
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    span_done |-> !span_busy);

  // R1
  col_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_wr_valid |-> !col_wr_data[15]);

  // R8
  col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_wr_valid && !col_wr_ready) |=>
      (col_wr_valid && $stable(col_wr_addr) && $stable(col_wr_data)));

  // R8
  dep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dep_wr_valid && !dep_wr_ready) |=>
      (dep_wr_valid && $stable(dep_wr_addr) && $stable(dep_wr_data)));

  // R2
  fail_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && !(pix_z > pix_zbuf)) |=> (!col_wr_valid && !dep_wr_valid));

  // R4
  pass_store_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && (pix_z > pix_zbuf)) |=>
      (col_wr_valid && dep_wr_valid && dep_wr_data == $past(pix_z)));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!span_busy && !span_done && !col_wr_valid && !dep_wr_valid));
endmodule

bind zpw_write_stage zpw_checker #(.AW(AW), .CNT_W(CNT_W), .CH_W(CH_W), .Z_W(Z_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .span_busy    (span_busy),
  .span_done    (span_done),
  .pix_valid    (pix_valid),
  .pix_ready    (pix_ready),
  .pix_z        (pix_z),
  .pix_zbuf     (pix_zbuf),
  .col_wr_valid (col_wr_valid),
  .col_wr_ready (col_wr_ready),
  .col_wr_addr  (col_wr_addr),
  .col_wr_data  (col_wr_data),
  .dep_wr_valid (dep_wr_valid),
  .dep_wr_ready (dep_wr_ready),
  .dep_wr_addr  (dep_wr_addr),
  .dep_wr_data  (dep_wr_data)
);

// File: tb/zpw_write_stage_tb_top.sv
module zpw_write_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        span_start = 1'b0;
  logic [31:0] span_col_base = '0, span_z_base = '0;
  logic [15:0] span_len = '0;
  logic        span_busy, span_done;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [15:0] pix_red = '0, pix_grn = '0, pix_blu = '0;
  logic [31:0] pix_z = '0, pix_zbuf = '0;
  logic        col_wr_valid, dep_wr_valid;
  logic        col_wr_ready = 1'b0, dep_wr_ready = 1'b0;
  logic [31:0] col_wr_addr, dep_wr_addr, dep_wr_data;
  logic [15:0] col_wr_data;

  always #2.5 clk = ~clk;

  zpw_write_stage dut_i (
    .clk(clk), .rst_n(rst_n),
    .span_start(span_start), .span_col_base(span_col_base), .span_z_base(span_z_base),
    .span_len(span_len), .span_busy(span_busy), .span_done(span_done),
    .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_red(pix_red), .pix_grn(pix_grn), .pix_blu(pix_blu),
    .pix_z(pix_z), .pix_zbuf(pix_zbuf),
    .col_wr_valid(col_wr_valid), .col_wr_ready(col_wr_ready),
    .col_wr_addr(col_wr_addr), .col_wr_data(col_wr_data),
    .dep_wr_valid(dep_wr_valid), .dep_wr_ready(dep_wr_ready),
    .dep_wr_addr(dep_wr_addr), .dep_wr_data(dep_wr_data)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // behavioural model state
  bit          m_busy = 0, m_done = 0;
  int          m_rem = 0;
  logic [31:0] m_idx = '0, m_cb = '0, m_zb = '0;
  bit          m_cwv = 0, m_zwv = 0;
  logic [31:0] m_cwa = '0, m_zwa = '0, m_zwd = '0;
  logic [15:0] m_cwd = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pick_pixel(input int zmode);
    pix_red = 16'($urandom);
    pix_grn = 16'($urandom);
    pix_blu = 16'($urandom);
    pix_zbuf = $urandom;
    case (zmode % 6)
      0: pix_z = pix_zbuf;                        // R2 tie fails
      1: pix_z = pix_zbuf + 32'd1;
      2: pix_z = pix_zbuf - 32'd1;
      3: pix_z = $urandom;
      4: begin pix_z = 32'hFFFF_FFFF; pix_zbuf = 32'h0; end
      default: begin pix_z = 32'h0; pix_zbuf = 32'hFFFF_FFFF; end // R2 unsigned
    endcase
  endtask

  task automatic step(input bit st, input int len, input logic [31:0] cb, input logic [31:0] zb,
                      input bit pv, input bit cr, input bit zr);
    bit rdy, acc, pass, nd;
    @(negedge clk);
    chk("R6 busy", 32'(span_busy), 32'(m_busy));
    chk("R7 done", 32'(span_done), 32'(m_done));
    chk("R2 R3 col valid", 32'(col_wr_valid), 32'(m_cwv));
    chk("R2 R4 dep valid", 32'(dep_wr_valid), 32'(m_zwv));
    if (m_cwv && col_wr_valid) begin
      chk("R5 col addr", col_wr_addr, m_cwa);
      chk("R1 col data", 32'(col_wr_data), 32'(m_cwd));
    end
    if (m_zwv && dep_wr_valid) begin
      chk("R5 dep addr", dep_wr_addr, m_zwa);
      chk("R4 dep data", dep_wr_data, m_zwd);
    end
    span_start = st; span_len = 16'(len); span_col_base = cb; span_z_base = zb;
    pix_valid = pv; col_wr_ready = cr; dep_wr_ready = zr;
    pick_pixel(int'($urandom % 6));
    #1;
    rdy = m_busy && (!m_cwv || cr) && (!m_zwv || zr);
    chk("R8 pix ready", 32'(pix_ready), 32'(rdy));
    acc  = pv && rdy;
    pass = pix_z > pix_zbuf;
    nd   = 0;
    if (m_cwv && cr) m_cwv = 0;
    if (m_zwv && zr) m_zwv = 0;
    if (acc) begin
      if (pass) begin
        m_cwv = 1; m_cwa = m_cb + 32'd2 * m_idx;
        m_cwd = {1'b0, pix_red[15:11], pix_grn[15:11], pix_blu[15:11]};
        m_zwv = 1; m_zwa = m_zb + 32'd4 * m_idx; m_zwd = pix_z;
      end
      m_idx = m_idx + 1;
      m_rem = m_rem - 1;
      if (m_rem == 0) begin m_busy = 0; nd = 1; end
    end else if (!m_busy && st) begin
      if (len == 0) nd = 1;
      else begin m_busy = 1; m_rem = len; m_idx = 0; m_cb = cb; m_zb = zb; end
    end
    m_done = nd;
  endtask

  // mode 0: always ready, 1: random valid and back-pressure, 2: also re-issue start while busy
  task automatic run_span(input logic [31:0] cb, input logic [31:0] zb, input int len, input int mode);
    int guard = 0;
    step(1, len, cb, zb, 0, 1, 1);
    while ((m_busy || m_cwv || m_zwv || m_done) && guard < 2000) begin
      if (mode == 0) step(0, 0, 0, 0, 1, 1, 1);
      else step(mode == 2 && ($urandom % 3 == 0), 5, 32'h5555_0000, 32'h6666_0000,
                ($urandom % 4 != 0), ($urandom % 3 != 0), ($urandom % 3 != 0));
      guard++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 during reset
    chk("R9 busy in reset", 32'(span_busy), 32'h0);
    chk("R9 valids in reset", 32'({col_wr_valid, dep_wr_valid, span_done}), 32'h0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0);
    run_span(32'h0000_1000, 32'h0000_8000, 6, 0);
    run_span(32'h0000_2000, 32'h0001_0000, 0, 0);   // R7 zero length
    step(0, 0, 0, 0, 0, 1, 1);
    run_span(32'h0000_3000, 32'h0002_0000, 20, 1);
    run_span(32'h0000_4000, 32'h0003_0000, 25, 2);  // R6 start while busy
    run_span(32'hFFFF_FFFC, 32'hFFFF_FFF8, 9, 1);   // R5 wrap
    for (int k = 0; k < 20; k++) run_span(32'($urandom) & 32'hFFFF_FFFE, 32'($urandom) & 32'hFFFF_FFFC,
                                          int'($urandom % 12), 1 + int'($urandom % 2));
    repeat (2) step(0, 0, 0, 0, 0, 1, 1);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule